// File: doc/BRIEF.md
# Sponge State Round Engine

This block holds a 320-bit sponge state as five 64-bit rows (X0 to X4) and runs a configurable number of permutation rounds over it. A round adds a round constant, then applies a nonlinear 5-bit substitution to every bit column, then diffuses each row with two rotated copies of itself. The substitution is serialized: the rows shift right through `N_SBOX` parallel 5-bit substitution units, so one substitution pass costs 64/`N_SBOX` cycles. The diffusion step always completes in one cycle.

An outer mode controller uses the block in two steps. First it loads the state from an initial value, a 128-bit key and a 128-bit nonce. Then it issues start commands with a round count: typically 12 rounds for initialization and finalization, and 6 rounds per absorbed 64-bit data block. At the start edge, the command can optionally XOR a data word into X0, overwrite X0 with it, or XOR the key into X3/X4. The round constants are produced inside the block from the round count.

Top module: `sponge_perm_core`

## Requirements
- R1: With the block idle, a `load_i` pulse sets, one cycle later, X0=`iv_i`, X1=`key_i[127:64]`, X2=`key_i[63:0]`, X3=`nonce_i[127:64]` and X4=`nonce_i[63:0]`.
- R2: When `load_i` and `start_i` are both high in an idle cycle, the load is performed and the start is dropped: `busy_o` stays low.
- R3: An accepted start first applies the `mode_i` operation at the start edge: 0 leaves the state unchanged, 1 XORs `data_i` into X0, 2 replaces X0 with `data_i`, 3 XORs `key_i[127:64]` into X3 and `key_i[63:0]` into X4.
- R4: For a count of n rounds, the round index runs from 12-n up to 11. Each round XORs the byte {15-idx, idx} (high nibble then low nibble) into bits 7:0 of X2.
- R5: The substitution maps every bit column (x0..x4 taken from bit k of X0..X4) through the 5-bit function: x0^=x4, x4^=x3, x2^=x1; ti=~xi&x(i+1 mod 5); xi^=t(i+1 mod 5); then x1^=x0, x0^=x4, x3^=x2, x2=~x2.
- R6: Diffusion replaces each row with itself XOR two right rotations: X0 by 19 and 28, X1 by 61 and 39, X2 by 1 and 6, X3 by 10 and 17, X4 by 7 and 41.
- R7: The final state and a one-cycle `done_o` pulse appear exactly n*(64/`N_SBOX`+2) clock edges after the start edge. `busy_o` is high from the cycle after the start edge until `done_o`, and low together with `done_o`.
- R8: A start with `rounds_i`=0 is ignored and leaves the state as it was. Counts above 12 run 12 rounds.
- R9: While busy, `load_i` and `start_i` have no effect on the result of the running permutation.
- R10: After reset all rows are zero. While the block is idle and neither strobe is high, the state holds its value whatever the data, key and nonce inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load state from iv, key and nonce (idle only) |
| start_i | input | 1 | Begin a permutation run (idle only) |
| rounds_i | input | 4 | Number of rounds for the run |
| mode_i | input | 2 | Absorb operation applied at the start edge |
| iv_i | input | 64 | Initial value for X0 on load |
| key_i | input | 128 | Key for load and key-XOR mode |
| nonce_i | input | 128 | Nonce for X3/X4 on load |
| data_i | input | 64 | Data word for absorb modes |
| x0_o | output | 64 | State row X0 |
| x1_o | output | 64 | State row X1 |
| x2_o | output | 64 | State row X2 |
| x3_o | output | 64 | State row X3 |
| x4_o | output | 64 | State row X4 |
| busy_o | output | 1 | Permutation in progress |
| done_o | output | 1 | One-cycle pulse when the run ends |

## Verification
A load is visible on the rows one edge after the strobe. A start is due n*(64/`N_SBOX`+2) edges after its own edge: one edge for the constant, 64/`N_SBOX` for the slices and one for diffusion, per round. The bench drives on the falling edge and samples there. It counts rising edges from the start edge until `done_o` is seen, compares that count with the formula, and then compares the rows with a word-level reference permutation. One edge later it confirms that `done_o` has dropped. Ignored strobes are checked by sampling busy and the rows in the cycle after the strobe, or at the end of the run they tried to disturb.

// File: rtl/sponge_pkg.sv
`timescale 1ns/1ps
package sponge_pkg;
    localparam int ROW_W      = 64;
    localparam int N_ROWS     = 5;
    localparam int MAX_ROUNDS = 12;

    typedef logic [ROW_W-1:0]       row_t;
    typedef row_t [N_ROWS-1:0]      state_t;

    typedef enum logic [1:0] {PH_IDLE, PH_CONST, PH_SUBST, PH_MIX} phase_e;
    typedef enum logic [1:0] {ABS_NONE, ABS_XOR, ABS_OVERWRITE, ABS_KEY} absorb_e;

    localparam int ROT_A [N_ROWS] = '{19, 61, 1, 10, 7};
    localparam int ROT_B [N_ROWS] = '{28, 39, 6, 17, 41};

    function automatic row_t ror(input row_t x, input int n);
        return (x >> n) | (x << (ROW_W - n));
    endfunction

    // column bit c[i] belongs to row Xi
    function automatic logic [4:0] sbox5(input logic [4:0] c);
        logic x0, x1, x2, x3, x4, t0, t1, t2, t3, t4;
        x0 = c[0] ^ c[4];
        x1 = c[1];
        x2 = c[2] ^ c[1];
        x3 = c[3];
        x4 = c[4] ^ c[3];
        t0 = ~x0 & x1;
        t1 = ~x1 & x2;
        t2 = ~x2 & x3;
        t3 = ~x3 & x4;
        t4 = ~x4 & x0;
        x0 = x0 ^ t1;
        x1 = x1 ^ t2;
        x2 = x2 ^ t3;
        x3 = x3 ^ t4;
        x4 = x4 ^ t0;
        x1 = x1 ^ x0;
        x0 = x0 ^ x4;
        x3 = x3 ^ x2;
        x2 = ~x2;
        return {x4, x3, x2, x1, x0};
    endfunction

    function automatic logic [7:0] round_const(input logic [3:0] idx);
        return {4'hF - idx, idx};
    endfunction
endpackage

// File: rtl/sponge_sbox_shift.sv
`timescale 1ns/1ps
module sponge_sbox_shift
    import sponge_pkg::*;
#(
    parameter int N_SBOX = 4
) (
    input  state_t cur_i,
    output state_t nxt_o
);
    logic [N_ROWS-1:0][N_SBOX-1:0] col_out;

    for (genvar k = 0; k < N_SBOX; k++) begin : g_col
        logic [4:0] cin;
        logic [4:0] cout;
        assign cin  = {cur_i[4][k], cur_i[3][k], cur_i[2][k], cur_i[1][k], cur_i[0][k]};
        assign cout = sbox5(cin);
        for (genvar j = 0; j < N_ROWS; j++) begin : g_bit
            assign col_out[j][k] = cout[j];
        end
    end

    for (genvar j = 0; j < N_ROWS; j++) begin : g_row
        if (N_SBOX == ROW_W) begin : g_full
            assign nxt_o[j] = col_out[j];
        end else begin : g_part
            assign nxt_o[j] = {col_out[j], cur_i[j][ROW_W-1:N_SBOX]};
        end
    end
endmodule

// File: rtl/sponge_diffuse.sv
`timescale 1ns/1ps
module sponge_diffuse
    import sponge_pkg::*;
(
    input  state_t cur_i,
    output state_t nxt_o
);
    for (genvar j = 0; j < N_ROWS; j++) begin : g_row
        assign nxt_o[j] = cur_i[j] ^ ror(cur_i[j], ROT_A[j]) ^ ror(cur_i[j], ROT_B[j]);
    end
endmodule

// File: rtl/sponge_round_ctrl.sv
`timescale 1ns/1ps
module sponge_round_ctrl
    import sponge_pkg::*;
#(
    parameter int N_SBOX = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic       start_i,
    input  logic [3:0] rounds_i,
    output logic       accept_load_o,
    output logic       accept_start_o,
    output phase_e     phase_o,
    output logic [7:0] rc_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int SLICES = ROW_W / N_SBOX;
    localparam int CW     = $clog2(SLICES + 1);
    localparam logic [CW-1:0] LAST_SLICE = CW'(SLICES - 1);
    localparam logic [3:0]    LAST_ROUND = 4'(MAX_ROUNDS - 1);

    phase_e        phase_q;
    logic [CW-1:0] slice_q;
    logic [3:0]    rnd_q;
    logic          done_q;
    logic [3:0]    first_idx;
    logic          idle;

    assign idle           = (phase_q == PH_IDLE);
    assign accept_load_o  = idle && load_i;
    assign accept_start_o = idle && !load_i && start_i && (rounds_i != 4'd0);
    assign first_idx      = (rounds_i >= 4'(MAX_ROUNDS)) ? 4'd0 : 4'(MAX_ROUNDS) - rounds_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            slice_q <= '0;
            rnd_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: if (accept_start_o) begin
                    rnd_q   <= first_idx;
                    phase_q <= PH_CONST;
                end
                PH_CONST: begin
                    slice_q <= '0;
                    phase_q <= PH_SUBST;
                end
                PH_SUBST: if (slice_q == LAST_SLICE) begin
                    slice_q <= '0;
                    phase_q <= PH_MIX;
                end else begin
                    slice_q <= slice_q + 1'b1;
                end
                PH_MIX: if (rnd_q == LAST_ROUND) begin
                    phase_q <= PH_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    rnd_q   <= rnd_q + 1'b1;
                    phase_q <= PH_CONST;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign rc_o    = round_const(rnd_q);
    assign busy_o  = !idle;
    assign done_o  = done_q;

    // R7
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
    // R7
    busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);
    // R9
    run_continues_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !(phase_q == PH_MIX && rnd_q == LAST_ROUND)) |=> busy_o);
    // R4
    round_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (rnd_q <= LAST_ROUND));
    // R5
    slice_range_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SUBST) |-> (slice_q <= LAST_SLICE));
endmodule

// File: rtl/sponge_perm_core.sv
`timescale 1ns/1ps
module sponge_perm_core
    import sponge_pkg::*;
#(
    parameter int N_SBOX = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         start_i,
    input  logic [3:0]   rounds_i,
    input  logic [1:0]   mode_i,
    input  logic [63:0]  iv_i,
    input  logic [127:0] key_i,
    input  logic [127:0] nonce_i,
    input  logic [63:0]  data_i,
    output logic [63:0]  x0_o,
    output logic [63:0]  x1_o,
    output logic [63:0]  x2_o,
    output logic [63:0]  x3_o,
    output logic [63:0]  x4_o,
    output logic         busy_o,
    output logic         done_o
);
    state_t     state_q, state_d, absorbed, subst_nxt, mix_nxt;
    phase_e     phase;
    logic [7:0] rc;
    logic       acc_load, acc_start;

    sponge_round_ctrl #(.N_SBOX(N_SBOX)) ctrl_i (
        .clk(clk), .rst(rst), .load_i(load_i), .start_i(start_i),
        .rounds_i(rounds_i), .accept_load_o(acc_load), .accept_start_o(acc_start),
        .phase_o(phase), .rc_o(rc), .busy_o(busy_o), .done_o(done_o)
    );

    sponge_sbox_shift #(.N_SBOX(N_SBOX)) sbox_i (.cur_i(state_q), .nxt_o(subst_nxt));
    sponge_diffuse mix_i (.cur_i(state_q), .nxt_o(mix_nxt));

    always_comb begin
        absorbed = state_q;
        unique case (absorb_e'(mode_i))
            ABS_XOR:       absorbed[0] = state_q[0] ^ data_i;
            ABS_OVERWRITE: absorbed[0] = data_i;
            ABS_KEY: begin
                absorbed[3] = state_q[3] ^ key_i[127:64];
                absorbed[4] = state_q[4] ^ key_i[63:0];
            end
            default: ;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (acc_load) begin
            state_d = {nonce_i[63:0], nonce_i[127:64], key_i[63:0], key_i[127:64], iv_i};
        end else if (acc_start) begin
            state_d = absorbed;
        end else begin
            unique case (phase)
                PH_CONST: state_d[2] = state_q[2] ^ {56'd0, rc};
                PH_SUBST: state_d    = subst_nxt;
                PH_MIX:   state_d    = mix_nxt;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign x0_o = state_q[0];
    assign x1_o = state_q[1];
    assign x2_o = state_q[2];
    assign x3_o = state_q[3];
    assign x4_o = state_q[4];

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !load_i && !start_i) |=> $stable(state_q));
    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && load_i) |=> !busy_o);
    // R8
    zero_rounds_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && rounds_i == 4'd0) |=> (!busy_o && $stable(state_q)));
endmodule

// File: tb/sponge_perm_core_tb.sv
`timescale 1ns/1ps
module sponge_perm_core_tb_top;
    localparam int NS     = 4;
    localparam int SLICES = 64 / NS;

    typedef logic [4:0][63:0] st_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0, start_i = 1'b0;
    logic [3:0]   rounds_i = '0;
    logic [1:0]   mode_i = '0;
    logic [63:0]  iv_i = '0, data_i = '0;
    logic [127:0] key_i = '0, nonce_i = '0;
    logic [63:0]  x0_o, x1_o, x2_o, x3_o, x4_o;
    logic         busy_o, done_o;

    int   n_checks = 0;
    int   n_fail   = 0;
    st_t  exp_st   = '0;

    always #10 clk = ~clk;

    sponge_perm_core #(.N_SBOX(NS)) dut_i (
        .clk(clk), .rst(rst), .load_i(load_i), .start_i(start_i),
        .rounds_i(rounds_i), .mode_i(mode_i), .iv_i(iv_i), .key_i(key_i),
        .nonce_i(nonce_i), .data_i(data_i), .x0_o(x0_o), .x1_o(x1_o),
        .x2_o(x2_o), .x3_o(x3_o), .x4_o(x4_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic st_t act();
        return {x4_o, x3_o, x2_o, x1_o, x0_o};
    endfunction

    function automatic logic [63:0] rr(input logic [63:0] v, input int n);
        return (v >> n) | (v << (64 - n));
    endfunction

    function automatic st_t ref_round(input st_t s, input int idx);
        logic [63:0] a, b, c, d, e, t0, t1, t2, t3, t4;
        s[2] = s[2] ^ {56'd0, 4'(15 - idx), 4'(idx)};
        a = s[0] ^ s[4]; b = s[1]; c = s[2] ^ s[1]; d = s[3]; e = s[4] ^ s[3];
        t0 = ~a & b; t1 = ~b & c; t2 = ~c & d; t3 = ~d & e; t4 = ~e & a;
        a = a ^ t1; b = b ^ t2; c = c ^ t3; d = d ^ t4; e = e ^ t0;
        b = b ^ a; a = a ^ e; d = d ^ c; c = ~c;
        s[0] = a ^ rr(a, 19) ^ rr(a, 28);
        s[1] = b ^ rr(b, 61) ^ rr(b, 39);
        s[2] = c ^ rr(c, 1)  ^ rr(c, 6);
        s[3] = d ^ rr(d, 10) ^ rr(d, 17);
        s[4] = e ^ rr(e, 7)  ^ rr(e, 41);
        return s;
    endfunction

    function automatic int eff_rounds(input int n);
        return (n > 12) ? 12 : n;
    endfunction

    function automatic st_t ref_perm(input st_t s, input int n);
        for (int r = 12 - eff_rounds(n); r < 12; r++) s = ref_round(s, r);
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [319:0] a, input logic [319:0] e);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic do_load(input logic [63:0] iv, input logic [127:0] key,
                           input logic [127:0] nonce, input bit with_start);
        @(negedge clk);
        iv_i = iv; key_i = key; nonce_i = nonce;
        load_i = 1'b1; start_i = with_start; rounds_i = 4'd12; mode_i = 2'd1;
        @(posedge clk);
        @(negedge clk);
        load_i = 1'b0; start_i = 1'b0;
        exp_st = {nonce[63:0], nonce[127:64], key[63:0], key[127:64], iv};
        check(act() == exp_st, with_start ? "R2 load state" : "R1 load state", act(), exp_st);
        if (with_start) check(busy_o == 1'b0, "R2 start dropped", 320'(busy_o), 320'(0));
    endtask

    task automatic run(input logic [1:0] mode, input logic [63:0] data,
                       input logic [127:0] key, input int n, input bit disturb, input string tag);
        st_t s;
        int  cyc;
        s = exp_st;
        case (mode)
            2'd1: s[0] = s[0] ^ data;
            2'd2: s[0] = data;
            2'd3: begin s[3] = s[3] ^ key[127:64]; s[4] = s[4] ^ key[63:0]; end
            default: ;
        endcase
        @(negedge clk);
        mode_i = mode; data_i = data; key_i = key; rounds_i = 4'(n); start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        data_i = {$urandom, $urandom}; key_i = {$urandom, $urandom, $urandom, $urandom};
        if (n == 0) begin
            check(busy_o == 1'b0 && act() == exp_st, "R8 zero rounds ignored", act(), exp_st);
            return;
        end
        s = ref_perm(s, n);
        check(busy_o == 1'b1, "R7 busy after start", 320'(busy_o), 320'(1));
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (disturb && cyc == 3) begin
                load_i = 1'b1; start_i = 1'b1; iv_i = {$urandom, $urandom}; rounds_i = 4'd1;
            end else begin
                load_i = 1'b0; start_i = 1'b0;
            end
            if (done_o || cyc > 2000) break;
        end
        load_i = 1'b0; start_i = 1'b0;
        check(cyc == eff_rounds(n) * (SLICES + 2), "R7 latency", 320'(cyc),
              320'(eff_rounds(n) * (SLICES + 2)));
        check(act() == s, tag, act(), s);
        check(busy_o == 1'b0, "R7 busy low at done", 320'(busy_o), 320'(0));
        exp_st = s;
        @(posedge clk);
        @(negedge clk);
        check(done_o == 1'b0, "R7 done single pulse", 320'(done_o), 320'(0));
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check(act() == '0 && !busy_o && !done_o, "R10 reset state", act(), '0);

        // R4 directed: one round on an all-zero state
        run(2'd0, 64'd0, 128'd0, 1, 1'b0, "R4 single round from zero");

        do_load({$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom}, 1'b0);
        // R5 R6 full 12-round permutation
        run(2'd0, 64'd0, 128'd0, 12, 1'b0, "R5 R6 twelve rounds");
        // R3 each absorb mode
        run(2'd1, {$urandom, $urandom}, 128'd0, 6, 1'b0, "R3 xor data");
        run(2'd2, 64'hFFFF_0000_A5A5_5A5A, 128'd0, 6, 1'b0, "R3 overwrite data");
        run(2'd3, 64'd0, {$urandom, $urandom, $urandom, $urandom}, 12, 1'b0, "R3 xor key");

        for (int i = 0; i < 6; i++) begin
            do_load({$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                    {$urandom, $urandom, $urandom, $urandom}, 1'b0);
            run(2'($urandom), {$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                1 + int'($urandom % 12), 1'b0, "R3 R4 random run");
        end

        // R8 zero count and clamp above twelve
        run(2'd1, {$urandom, $urandom}, 128'd0, 0, 1'b0, "R8 zero rounds");
        run(2'd0, 64'd0, 128'd0, 15, 1'b0, "R8 fifteen runs as twelve");

        // R2 load and start together
        do_load({$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom}, 1'b1);

        // R9 strobes during a run
        run(2'd1, {$urandom, $urandom}, 128'd0, 6, 1'b1, "R9 strobes while busy");

        // R10 idle hold with changing inputs
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            iv_i = {$urandom, $urandom}; data_i = {$urandom, $urandom};
            key_i = {$urandom, $urandom, $urandom, $urandom}; mode_i = 2'($urandom);
            @(posedge clk);
            @(negedge clk);
            check(act() == exp_st && !busy_o, "R10 idle hold", act(), exp_st);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule